// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This block is the last stage of a double-precision floating-point datapath. An arithmetic stage ahead of it supplies the exact result in unpacked form: a sign, a signed unbiased exponent and a 56-bit significand. The significand has the leading one at bit 55, 52 fraction bits below it and 3 guard bits at the bottom. The unit rounds that value under one of four rounding modes. When the exponent is below the normal range, it first shifts the significand right and folds the lost bits into a sticky bit. It then packs the binary64 word and reports overflow, underflow and inexact.

Exponents above the largest normal value saturate. The result is infinity or the largest finite value, chosen from the rounding mode and the sign. A separate flush control replaces every under-range input with a zero or the smallest denormal, again chosen from the mode and the sign. A second control, for underflow trapping, makes exact denormal results raise underflow as well. The logic is combinational and is followed by an optional output register, so the default latency is one clock.

Top module: `fp64_round_pack`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o` and `flags_o` become zero. With the default output register, a result appears on the outputs one clock edge after its inputs were applied.
- R2: For an in-range exponent E and exact guard bits (bits 2:0 zero), the result is {sign, E+1023, significand bits 54:3} with flags 3'b000. Flags are ordered {overflow, underflow, inexact} from bit 2 down to bit 0.
- R3: In mode 0 (nearest), nonzero guard bits round to the nearest value. A tie, guard = 3'b100, rounds to the even fraction: it rounds up only when bit 3 is one. Any rounding sets inexact.
- R4: Mode 1 (toward zero) truncates. Mode 2 (toward +inf) adds one unit at bit 3 only for a positive sign, and mode 3 (toward -inf) only for a negative sign. In every mode, nonzero guard bits set inexact.
- R5: A carry out of bit 55 during rounding shifts the significand right by one and increments the exponent.
- R6: A final exponent above 1023 gives flags 3'b101. Mode 0 gives signed infinity and mode 1 the signed largest finite value. Mode 2 gives +inf when positive and -max when negative. Mode 3 gives +max when positive and -inf when negative.
- R7: With flush enabled, an input exponent below -1022 gives flags 3'b011. Modes 0 and 1 give signed zero. Mode 2 gives the smallest positive denormal when positive and -0 when negative. Mode 3 gives +0 when positive and the smallest negative denormal when negative.
- R8: With flush disabled, an input exponent E below -1022 is handled by a right shift of (-1022 - E). Shifted-out bits are ORed into bit 0, and the packed exponent field is zero if the hidden bit is then clear.
- R9: A denormalised value whose guard bits are nonzero before rounding sets both underflow and inexact.
- R10: An exact denormal result raises underflow only when `uf_trap_en_i` is high. Otherwise its flags are 3'b000.
- R11: For an input exponent of exactly -1023, if rounding the unshifted significand carries out of bit 55, the result is the smallest normal value (exponent field 1, fraction 0) with flags 3'b001.
- R12: Shift distances of 56 or more collapse the whole significand into the sticky bit, for inputs as low as -4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sign_i | input | 1 | Sign of the unpacked value |
| exp_i | input | 13 | Unbiased exponent, two's complement |
| sig_i | input | 56 | Significand: hidden bit 55, fraction 54:3, guard 2:0 |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| flush_en_i | input | 1 | Replace under-range results by zero or the smallest denormal |
| uf_trap_en_i | input | 1 | Raise underflow on exact denormal results |
| result_o | output | 64 | Packed binary64 result |
| flags_o | output | 3 | {overflow, underflow, inexact} |

## Verification
The hardest case to reach from the ports is the promotion path at exponent -1023. It only appears when rounding the unshifted significand carries out of the top bit, and the same input must take the ordinary shift path under another mode. The bench drives an all-ones significand at exponent -1023 under nearest and then under toward-zero, expecting the smallest normal in the first case and the largest denormal with underflow in the second. It also reaches the sticky collapse by driving the most negative 13-bit exponent, so that every significand bit is shifted out.

// File: rtl/fprp_pkg.sv
package fprp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } fp_flags_t;

endpackage

// File: rtl/fprp_rounder.sv
module fprp_rounder
  import fprp_pkg::*;
#(
  parameter int SIG_W = 56,
  parameter int GRD_W = 3
) (
  input  logic             sign,
  input  rmode_e           mode,
  input  logic [SIG_W-1:0] sig,
  output logic [SIG_W:0]   rounded,
  output logic             guard_nz
);

  localparam logic [SIG_W:0] ONE_ULP  = (SIG_W+1)'(1) << GRD_W;
  localparam logic [SIG_W:0] HALF_M1  = ((SIG_W+1)'(1) << (GRD_W-1)) - (SIG_W+1)'(1);

  logic [SIG_W:0] incr;

  assign guard_nz = |sig[GRD_W-1:0];

  always_comb begin
    incr = '0;
    if (guard_nz) begin
      unique case (mode)
        RM_NEAR: incr = HALF_M1 + (SIG_W+1)'(sig[GRD_W]);
        RM_ZERO: incr = '0;
        RM_UP:   incr = sign ? '0 : ONE_ULP;
        RM_DOWN: incr = sign ? ONE_ULP : '0;
        default: incr = '0;
      endcase
    end
  end

  assign rounded = {1'b0, sig} + incr;

endmodule

// File: rtl/fprp_shifter.sv
module fprp_shifter #(
  parameter int SIG_W = 56,
  parameter int AMT_W = 15
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [AMT_W-1:0] amt,
  output logic [SIG_W-1:0] shifted
);

  localparam logic [AMT_W-1:0] AMT_MAX = AMT_W'(SIG_W);

  logic [AMT_W-1:0] amt_c;
  logic [SIG_W:0]   lost_mask;
  logic [SIG_W-1:0] raw;
  logic             sticky;

  assign amt_c     = (amt >= AMT_MAX) ? AMT_MAX : amt;
  assign lost_mask = ((SIG_W+1)'(1) << amt_c) - (SIG_W+1)'(1);
  assign sticky    = |(sig & lost_mask[SIG_W-1:0]);
  assign raw       = sig >> amt_c;
  assign shifted   = {raw[SIG_W-1:1], raw[0] | sticky};

endmodule

// File: rtl/fprp_special.sv
module fprp_special
  import fprp_pkg::*;
#(
  parameter int EF_W   = 11,
  parameter int FRAC_W = 52
) (
  input  logic                   sign,
  input  rmode_e                 mode,
  output logic [EF_W+FRAC_W:0]   ovf_word,
  output logic [EF_W+FRAC_W:0]   flush_word
);

  logic [EF_W+FRAC_W-1:0] mag_inf, mag_max, mag_zero, mag_tiny;

  assign mag_inf  = {{EF_W{1'b1}}, {FRAC_W{1'b0}}};
  assign mag_max  = {{(EF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  assign mag_zero = '0;
  assign mag_tiny = {{(EF_W+FRAC_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (mode)
      RM_NEAR: ovf_word = {sign, mag_inf};
      RM_ZERO: ovf_word = {sign, mag_max};
      RM_UP:   ovf_word = {sign, sign ? mag_max : mag_inf};
      RM_DOWN: ovf_word = {sign, sign ? mag_inf : mag_max};
      default: ovf_word = {sign, mag_inf};
    endcase
  end

  always_comb begin
    unique case (mode)
      RM_NEAR, RM_ZERO: flush_word = {sign, mag_zero};
      RM_UP:   flush_word = {sign, sign ? mag_zero : mag_tiny};
      RM_DOWN: flush_word = {sign, sign ? mag_tiny : mag_zero};
      default: flush_word = {sign, mag_zero};
    endcase
  end

endmodule

// File: rtl/fp64_round_pack.sv
module fp64_round_pack
  import fprp_pkg::*;
#(
  parameter int  EXP_W   = 13,
  parameter int  EF_W    = 11,
  parameter int  FRAC_W  = 52,
  parameter int  GRD_W   = 3,
  parameter bit  REG_OUT = 1'b1,
  localparam int SIG_W   = FRAC_W + 1 + GRD_W,
  localparam int WORD_W  = 1 + EF_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [1:0]        rmode_i,
  input  logic              flush_en_i,
  input  logic              uf_trap_en_i,
  output logic [WORD_W-1:0] result_o,
  output logic [2:0]        flags_o
);

  localparam int IE_W = EXP_W + 2;
  localparam int EMAX = (1 << (EF_W - 1)) - 1;
  localparam int EMIN = 1 - EMAX;
  localparam logic signed [IE_W-1:0] EMAX_V  = IE_W'(EMAX);
  localparam logic signed [IE_W-1:0] EMIN_V  = IE_W'(EMIN);
  localparam logic signed [IE_W-1:0] EDGE_V  = IE_W'(EMIN - 1);
  localparam logic signed [IE_W-1:0] BIAS_V  = IE_W'(EMAX);

  rmode_e mode;
  assign mode = rmode_e'(rmode_i);

  // Stage 0: widen the exponent and classify the range
  logic signed [IE_W-1:0] e_in;
  logic signed [IE_W-1:0] deficit;
  logic                   below, at_edge;

  assign e_in    = {{2{exp_i[EXP_W-1]}}, exp_i};
  assign below   = e_in < EMIN_V;
  assign at_edge = e_in == EDGE_V;
  assign deficit = EMIN_V - e_in;

  // Pre-round of the unshifted significand, used at the edge exponent only
  logic [SIG_W:0] pre_rnd;
  logic           pre_gnz;

  fprp_rounder #(.SIG_W(SIG_W), .GRD_W(GRD_W)) u_pre_rnd (
    .sign     (sign_i),
    .mode     (mode),
    .sig      (sig_i),
    .rounded  (pre_rnd),
    .guard_nz (pre_gnz)
  );

  logic promote;
  assign promote = at_edge && pre_rnd[SIG_W];

  // Denormalising shift with sticky collection
  logic [SIG_W-1:0] den_sig;

  fprp_shifter #(.SIG_W(SIG_W), .AMT_W(IE_W)) u_shift (
    .sig     (sig_i),
    .amt     (deficit),
    .shifted (den_sig)
  );

  // Stage 1: bring the value into range
  logic [SIG_W-1:0]       m1;
  logic signed [IE_W-1:0] e1;
  logic                   inx1;

  always_comb begin
    m1   = sig_i;
    e1   = e_in;
    inx1 = 1'b0;
    if (below) begin
      e1 = EMIN_V;
      if (promote) begin
        m1   = {pre_rnd[SIG_W:GRD_W+1], {GRD_W{1'b0}}};
        inx1 = 1'b1;
      end else begin
        m1 = den_sig;
      end
    end
  end

  // Stage 2: final rounding
  logic [SIG_W:0] rnd;
  logic           gnz;

  fprp_rounder #(.SIG_W(SIG_W), .GRD_W(GRD_W)) u_main_rnd (
    .sign     (sign_i),
    .mode     (mode),
    .sig      (m1),
    .rounded  (rnd),
    .guard_nz (gnz)
  );

  logic [SIG_W-1:0]       m2;
  logic signed [IE_W-1:0] e2;
  logic                   inx2, unf2;

  always_comb begin
    m2   = m1;
    e2   = e1;
    inx2 = 1'b0;
    unf2 = 1'b0;
    if (gnz) begin
      inx2 = 1'b1;
      unf2 = ~m1[SIG_W-1];
      if (rnd[SIG_W]) begin
        m2 = rnd[SIG_W:1];
        e2 = e1 + IE_W'(1);
      end else begin
        m2 = rnd[SIG_W-1:0];
      end
    end
  end

  // Stage 3: drop guard bits and pack
  logic [FRAC_W:0]        m3;
  logic signed [IE_W-1:0] e_biased;
  logic                   ovf;

  assign m3       = m2[SIG_W-1:GRD_W];
  assign ovf      = e2 > EMAX_V;
  assign e_biased = e2 + BIAS_V;

  logic [WORD_W-1:0] ovf_word, flush_word;

  fprp_special #(.EF_W(EF_W), .FRAC_W(FRAC_W)) u_special (
    .sign       (sign_i),
    .mode       (mode),
    .ovf_word   (ovf_word),
    .flush_word (flush_word)
  );

  logic [WORD_W-1:0] word_c;
  fp_flags_t         flg_c;

  always_comb begin
    flg_c.ovf = 1'b0;
    flg_c.unf = unf2;
    flg_c.inx = inx1 | inx2;
    if (below && flush_en_i) begin
      word_c    = flush_word;
      flg_c.ovf = 1'b0;
      flg_c.unf = 1'b1;
      flg_c.inx = 1'b1;
    end else if (ovf) begin
      word_c    = ovf_word;
      flg_c.ovf = 1'b1;
      flg_c.inx = 1'b1;
    end else if (!m3[FRAC_W]) begin
      word_c    = {sign_i, {EF_W{1'b0}}, m3[FRAC_W-1:0]};
      flg_c.unf = unf2 | uf_trap_en_i;
    end else begin
      word_c    = {sign_i, e_biased[EF_W-1:0], m3[FRAC_W-1:0]};
    end
  end

  // Optional output register
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result_o <= '0;
          flags_o  <= '0;
        end else begin
          result_o <= word_c;
          flags_o  <= flg_c;
        end
      end
    end else begin : g_comb
      assign result_o = word_c;
      assign flags_o  = flg_c;
    end
  endgenerate

endmodule

// File: rtl/fp64_round_pack_chk.sv
module fp64_round_pack_chk #(
  parameter int EXP_W   = 13,
  parameter int EF_W    = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst,
  input logic [EXP_W-1:0]         exp_i,
  input logic                     flush_en_i,
  input logic                     uf_trap_en_i,
  input logic [EF_W+FRAC_W:0]     result_o,
  input logic [2:0]               flags_o
);

  localparam int EMIN = 2 - (1 << (EF_W - 1));

  logic [EF_W-1:0] efield;
  logic            flush_req;

  assign efield    = result_o[EF_W+FRAC_W-1:FRAC_W];
  assign flush_req = flush_en_i && (signed'(exp_i) < EMIN);

  // R6: overflow always comes with inexact
  a_r6_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
    flags_o[2] |-> flags_o[0]);

  // R6: overflow words carry the all-ones or max-finite exponent field
  a_r6_ovf_field: assert property (@(posedge clk) disable iff (rst)
    flags_o[2] |-> (efield >= {{(EF_W-1){1'b1}}, 1'b0}));

  // R6: an infinity is only produced by overflow
  a_r6_inf_needs_ovf: assert property (@(posedge clk) disable iff (rst)
    (efield == {EF_W{1'b1}}) |-> flags_o[2]);

  // R10: an exact underflow is only reported for a denormal word
  a_r10_exact_uf_denormal: assert property (@(posedge clk) disable iff (rst)
    (flags_o[1] && !flags_o[0]) |-> (efield == '0));

  generate
    if (REG_OUT) begin : g_lat
      // R7: a flushed input yields a zero-field word and flags 011
      a_r7_flush_word: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flush_req)) |->
          (flags_o == 3'b011 && efield == '0 && result_o[FRAC_W-1:1] == '0));

      // R10: without trap enable, underflow never appears without inexact
      a_r10_no_trap_no_exact_uf: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(uf_trap_en_i) && !flags_o[0]) |-> !flags_o[1]);
    end
  endgenerate

endmodule

bind fp64_round_pack fp64_round_pack_chk #(
  .EXP_W(EXP_W), .EF_W(EF_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .exp_i        (exp_i),
  .flush_en_i   (flush_en_i),
  .uf_trap_en_i (uf_trap_en_i),
  .result_o     (result_o),
  .flags_o      (flags_o)
);

// File: tb/fp64_round_pack_test.sv
`timescale 1ns/1ps
module fp64_round_pack_test;

  localparam logic [55:0] HID  = 56'h80000000000000;
  localparam logic [55:0] ONES = 56'hFFFFFFFFFFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sign_i = 1'b0;
  logic [12:0] exp_i = '0;
  logic [55:0] sig_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        flush_en_i = 1'b0;
  logic        uf_trap_en_i = 1'b0;
  logic [63:0] result_o;
  logic [2:0]  flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fp64_round_pack uut (
    .clk          (clk),
    .rst          (rst),
    .sign_i       (sign_i),
    .exp_i        (exp_i),
    .sig_i        (sig_i),
    .rmode_i      (rmode_i),
    .flush_en_i   (flush_en_i),
    .uf_trap_en_i (uf_trap_en_i),
    .result_o     (result_o),
    .flags_o      (flags_o)
  );

  task automatic check(input string req, input logic [63:0] exp_w, input logic [2:0] exp_f);
    n_chk++;
    if (result_o !== exp_w || flags_o !== exp_f) begin
      n_fail++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, result_o, flags_o, exp_w, exp_f);
    end
  endtask

  task automatic apply(input logic s, input int e, input logic [55:0] m, input logic [1:0] rm,
                       input logic fl, input logic tr);
    @(negedge clk);
    sign_i = s; exp_i = e[12:0]; sig_i = m; rmode_i = rm;
    flush_en_i = fl; uf_trap_en_i = tr;
    @(negedge clk);
  endtask

  task automatic run(input string req, input logic s, input int e, input logic [55:0] m,
                     input logic [1:0] rm, input logic fl, input logic tr,
                     input logic [63:0] w, input logic [2:0] f);
    apply(s, e, m, rm, fl, tr);
    check(req, w, f);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset", 64'h0, 3'b000);
    rst = 1'b0;
    sign_i = 1'b0; exp_i = '0; sig_i = HID;
    #2 check("R1 latency before edge", 64'h0, 3'b000);
    @(negedge clk);
    check("R1 latency after edge", 64'h3FF0000000000000, 3'b000);
  endtask

  task automatic t_normal;
    run("R2 one", 1'b0, 0, HID, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b000);
    run("R2 max exp neg", 1'b1, 1023, HID | 56'h8, 2'd0, 1'b0, 1'b0, 64'hFFE0000000000001, 3'b000);
  endtask

  task automatic t_nearest;
    run("R3 tie even down", 1'b0, 0, HID | 56'h4, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001);
    run("R3 tie odd up", 1'b0, 0, HID | 56'hC, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000002, 3'b001);
    run("R3 below half", 1'b0, 0, HID | 56'h3, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001);
    run("R3 above half", 1'b0, 0, HID | 56'h5, 2'd0, 1'b0, 1'b0, 64'h3FF0000000000001, 3'b001);
  endtask

  task automatic t_directed;
    run("R4 toward zero", 1'b0, 0, HID | 56'h7, 2'd1, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001);
    run("R4 up pos", 1'b0, 0, HID | 56'h1, 2'd2, 1'b0, 1'b0, 64'h3FF0000000000001, 3'b001);
    run("R4 up neg", 1'b1, 0, HID | 56'h1, 2'd2, 1'b0, 1'b0, 64'hBFF0000000000000, 3'b001);
    run("R4 down neg", 1'b1, 0, HID | 56'h1, 2'd3, 1'b0, 1'b0, 64'hBFF0000000000001, 3'b001);
    run("R4 down pos", 1'b0, 0, HID | 56'h1, 2'd3, 1'b0, 1'b0, 64'h3FF0000000000000, 3'b001);
  endtask

  task automatic t_carry;
    run("R5 carry out", 1'b0, 0, ONES, 2'd0, 1'b0, 1'b0, 64'h4000000000000000, 3'b001);
  endtask

  task automatic t_overflow;
    run("R6 near pos", 1'b0, 1024, HID, 2'd0, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101);
    run("R6 zero neg", 1'b1, 1024, HID, 2'd1, 1'b0, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101);
    run("R6 up pos", 1'b0, 1024, HID, 2'd2, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101);
    run("R6 up neg", 1'b1, 1024, HID, 2'd2, 1'b0, 1'b0, 64'hFFEFFFFFFFFFFFFF, 3'b101);
    run("R6 down pos", 1'b0, 1024, HID, 2'd3, 1'b0, 1'b0, 64'h7FEFFFFFFFFFFFFF, 3'b101);
    run("R6 down neg", 1'b1, 1024, HID, 2'd3, 1'b0, 1'b0, 64'hFFF0000000000000, 3'b101);
    run("R6 R5 carry into ovf", 1'b0, 1023, ONES, 2'd0, 1'b0, 1'b0, 64'h7FF0000000000000, 3'b101);
  endtask

  task automatic t_flush;
    run("R7 near neg", 1'b1, -1023, HID, 2'd0, 1'b1, 1'b0, 64'h8000000000000000, 3'b011);
    run("R7 zero pos", 1'b0, -2000, HID, 2'd1, 1'b1, 1'b0, 64'h0000000000000000, 3'b011);
    run("R7 up pos", 1'b0, -1023, HID, 2'd2, 1'b1, 1'b0, 64'h0000000000000001, 3'b011);
    run("R7 up neg", 1'b1, -1023, HID, 2'd2, 1'b1, 1'b0, 64'h8000000000000000, 3'b011);
    run("R7 down pos", 1'b0, -1023, HID, 2'd3, 1'b1, 1'b0, 64'h0000000000000000, 3'b011);
    run("R7 down neg", 1'b1, -1023, HID, 2'd3, 1'b1, 1'b0, 64'h8000000000000001, 3'b011);
    run("R7 in range untouched", 1'b0, -1022, HID, 2'd0, 1'b1, 1'b0, 64'h0010000000000000, 3'b000);
  endtask

  task automatic t_denormal;
    run("R8 R10 exact no trap", 1'b0, -1023, HID, 2'd0, 1'b0, 1'b0, 64'h0008000000000000, 3'b000);
    run("R10 exact with trap", 1'b0, -1023, HID, 2'd0, 1'b0, 1'b1, 64'h0008000000000000, 3'b010);
    run("R8 smallest exact", 1'b0, -1074, HID, 2'd0, 1'b0, 1'b0, 64'h0000000000000001, 3'b000);
    run("R9 tie to zero", 1'b0, -1075, HID, 2'd0, 1'b0, 1'b0, 64'h0000000000000000, 3'b011);
    run("R9 up to tiny", 1'b0, -1075, HID, 2'd2, 1'b0, 1'b0, 64'h0000000000000001, 3'b011);
  endtask

  task automatic t_edge;
    run("R11 promote", 1'b0, -1023, ONES, 2'd0, 1'b0, 1'b1, 64'h0010000000000000, 3'b001);
    run("R11 R8 no promote rz", 1'b0, -1023, ONES, 2'd1, 1'b0, 1'b0, 64'h000FFFFFFFFFFFFF, 3'b011);
  endtask

  task automatic t_deep;
    run("R12 deepest up", 1'b0, -4096, HID, 2'd2, 1'b0, 1'b0, 64'h0000000000000001, 3'b011);
    run("R12 deepest near", 1'b1, -4096, HID, 2'd0, 1'b0, 1'b0, 64'h8000000000000000, 3'b011);
    run("R12 shift 56 down", 1'b1, -1078, HID, 2'd3, 1'b0, 1'b0, 64'h8000000000000001, 3'b011);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_normal();
    t_nearest();
    t_directed();
    t_carry();
    t_overflow();
    t_flush();
    t_denormal();
    t_edge();
    t_deep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule